// File: doc/BRIEF.md
# Antenna Switch Pattern Sequencer

This block holds a short list of antenna-select patterns and plays them onto a set of antenna-select outputs while a direction-finding tone is sent or received. Software appends patterns one at a time through a single write port. A clear strobe empties the list. Each pattern is a binary word, and bit i of the stored word drives `antSel[i]`. The width of `antSel` is set by the `NUM_OUTS` parameter, from 1 to 8.

A start pulse begins a tone period. The sequencer then leaves its resting phase and moves through a guard phase, a reference phase and a switch-and-sample phase before it comes back to rest. The `halfTick` input paces it. Every pulse on `halfTick` marks half a slot, so one slot takes two pulses. The guard, reference and switch phases each last a number of slots given by a run-time input; typical values are 4 guard slots and 8 reference slots, and each length must be non-zero.

The resting phase shows entry 0. This covers both the time the payload is sent and the time the sequencer has let go of the antennas. The guard and reference phases show entry 1. The switch phase walks through entry 2 and the entries after it, and when it reaches the end of the list it goes back to entry 2. A one-cycle sample strobe marks the middle of each reference slot and each switch slot.

Top module: `antSwitchSeq`

## Requirements
- R1: After synchronous reset, `phase` is 0, `antSel` is all zero, and `sampleStb`, `cfgErr` and `wrReject` are low.
- R2: Each accepted write of `patWrData` goes into the next free entry, starting at entry 0. In the resting phase (`phase` = 0), `antSel[i]` equals bit i of entry 0.
- R3: The `phase` output uses 0 for rest, 1 for guard, 2 for reference and 3 for switch. An accepted start leads to guard on the next cycle. Each phase ends after its programmed slot count, where a slot is two `halfTick` pulses, and the next phase begins on the cycle after the second pulse of the last slot. The switch phase returns to rest.
- R4: While `phase` is 1 or 2, `antSel` shows entry 1.
- R5: On entering the switch phase, `antSel` shows entry 2. At the end of each switch slot it moves to the next entry. After the last stored entry it goes back to entry 2.
- R6: `sampleStb` is high for exactly the cycle of the first `halfTick` pulse of each reference slot and each switch slot. It is never high in rest or guard.
- R7: A start pulse in rest while fewer than 3 entries are stored leaves the block in rest and sets the sticky `cfgErr` flag.
- R8: The list holds `DEPTH` entries (40 by default). A write while the list is full is dropped and sets the sticky `wrReject` flag.
- R9: A write whose value has a bit set at position `NUM_OUTS` or above is dropped and sets `wrReject`.
- R10: `patClear` zeroes every entry, resets the write position to entry 0, clears `cfgErr` and `wrReject`, and returns the block to rest, all on the next cycle. A clear takes priority over a write in the same cycle.
- R11: A start pulse while the block is not in rest has no effect on the phase or on the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| patWrEn | input | 1 | Append `patWrData` to the pattern list |
| patWrData | input | 8 | Pattern value to append |
| patClear | input | 1 | Empty the list, clear the flags and return to rest |
| toneStart | input | 1 | Begin a tone period |
| halfTick | input | 1 | Half-slot pacing pulse |
| guardSlots | input | 8 | Guard phase length in slots |
| refSlots | input | 8 | Reference phase length in slots |
| switchSlots | input | 8 | Switch phase length in slots |
| antSel | output | NUM_OUTS | Active antenna pattern |
| phase | output | 2 | Current phase (0 rest, 1 guard, 2 reference, 3 switch) |
| sampleStb | output | 1 | Mid-slot sample strobe |
| cfgErr | output | 1 | Sticky flag: start was refused because too few patterns were stored |
| wrReject | output | 1 | Sticky flag: a write was dropped |

## Verification
Some behaviour holds on every cycle and is checked by properties alone. Phase changes only ever step forward by one, unless a clear intervened. The switch index stays between entry 2 and the last stored entry. The fill count never exceeds capacity. A sample strobe is never followed by another one on the next cycle. A refused start leaves the block in rest with the error flag set.

Other behaviour only shows up in the bench scenarios, where a scoreboard compares the outputs with a model cycle by cycle. This covers which pattern actually reaches the outputs in each phase, the exact cycles at which phases change under uneven tick spacing, wrap-around in both a short list and a full 40-entry list, and the effect of dropped writes, mid-tone starts and mid-tone clears.

// File: rtl/antSeqPkg.sv
package antSeqPkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GUARD  = 2'd1,
    PH_REF    = 2'd2,
    PH_SWITCH = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic swLoad;  // entering switch phase: point at first switch entry
    logic swStep;  // end of a switch slot: advance to next entry
  } seqCmd_t;

  localparam int MIN_PATTERNS   = 3;
  localparam int FIRST_SW_ENTRY = 2;
  localparam int PAT_W          = 8;
endpackage

// File: rtl/antSeqCtrl.sv
module antSeqCtrl
  import antSeqPkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              start,
  input  logic              halfTick,
  input  logic              enough,
  input  logic [SLOT_W-1:0] guardSlots,
  input  logic [SLOT_W-1:0] refSlots,
  input  logic [SLOT_W-1:0] switchSlots,
  output phase_e            phase,
  output logic              sampleStb,
  output logic              cfgErr,
  output seqCmd_t           cmd
);
  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] slotLimit;
  logic              secondHalf;
  logic              slotEnd;
  logic              lastSlot;
  phase_e            phaseNext;

  always_comb begin
    case (phase)
      PH_GUARD:  begin slotLimit = guardSlots;  phaseNext = PH_REF;    end
      PH_REF:    begin slotLimit = refSlots;    phaseNext = PH_SWITCH; end
      PH_SWITCH: begin slotLimit = switchSlots; phaseNext = PH_IDLE;   end
      default:   begin slotLimit = '0;          phaseNext = PH_GUARD;  end
    endcase
  end

  assign slotEnd    = halfTick && secondHalf && (phase != PH_IDLE);
  assign lastSlot   = (slotCnt == slotLimit - SLOT_W'(1));
  assign sampleStb  = halfTick && !secondHalf && (phase == PH_REF || phase == PH_SWITCH);
  assign cmd.swLoad = slotEnd && lastSlot && (phase == PH_REF);
  assign cmd.swStep = slotEnd && (phase == PH_SWITCH);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase      <= PH_IDLE;
      slotCnt    <= '0;
      secondHalf <= 1'b0;
      cfgErr     <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        if (enough) begin
          phase      <= phaseNext;
          slotCnt    <= '0;
          secondHalf <= 1'b0;
        end else begin
          cfgErr <= 1'b1;
        end
      end
    end else if (halfTick) begin
      secondHalf <= !secondHalf;
      if (secondHalf) begin
        if (lastSlot) begin
          slotCnt <= '0;
          phase   <= phaseNext;
        end else begin
          slotCnt <= slotCnt + SLOT_W'(1);
        end
      end
    end
  end

  // R3
  phase_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) && !$past(clr) && !$past(rst)
      |-> (2'(phase) == 2'($past(phase)) + 2'd1));

  // R7
  cfg_err_chk: assert property (@(posedge clk) disable iff (rst)
    start && !clr && (phase == PH_IDLE) && !enough |=> cfgErr && (phase == PH_IDLE));

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStb |=> !sampleStb);
endmodule

// File: rtl/antSeqData.sv
module antSeqData
  import antSeqPkg::*;
#(
  parameter int NUM_OUTS = 4,
  parameter int DEPTH    = 40,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                wrEn,
  input  logic [PAT_W-1:0]    wrData,
  input  phase_e              phase,
  input  seqCmd_t             cmd,
  output logic [NUM_OUTS-1:0] antSel,
  output logic                enough,
  output logic                wrReject
);
  localparam logic [PAT_W-1:0] OUT_MASK = PAT_W'((1 << NUM_OUTS) - 1);

  logic [PAT_W-1:0] memQ [DEPTH];
  logic [CW-1:0]    wrCount;
  logic [IW-1:0]    swIdx;
  logic [IW-1:0]    readIdx;
  logic             inRange;
  logic             hasRoom;
  logic             accept;

  assign inRange = (wrData & ~OUT_MASK) == '0;
  assign hasRoom = wrCount < CW'(DEPTH);
  assign accept  = wrEn && inRange && hasRoom;
  assign enough  = wrCount >= CW'(MIN_PATTERNS);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int e = 0; e < DEPTH; e++) memQ[e] <= '0;
      wrCount  <= '0;
      wrReject <= 1'b0;
      swIdx    <= IW'(FIRST_SW_ENTRY);
    end else begin
      if (wrEn) begin
        if (accept) begin
          memQ[wrCount[IW-1:0]] <= wrData;
          wrCount <= wrCount + CW'(1);
        end else begin
          wrReject <= 1'b1;
        end
      end
      if (cmd.swLoad) begin
        swIdx <= IW'(FIRST_SW_ENTRY);
      end else if (cmd.swStep) begin
        swIdx <= (CW'(swIdx) == wrCount - CW'(1)) ? IW'(FIRST_SW_ENTRY) : swIdx + IW'(1);
      end
    end
  end

  always_comb begin
    case (phase)
      PH_GUARD, PH_REF: readIdx = IW'(1);
      PH_SWITCH:        readIdx = swIdx;
      default:          readIdx = '0;
    endcase
  end

  assign antSel = memQ[readIdx][NUM_OUTS-1:0];

  // R5
  sw_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SWITCH) |-> (swIdx >= IW'(FIRST_SW_ENTRY)) && (CW'(swIdx) < wrCount));

  // R8
  mem_cap_chk: assert property (@(posedge clk) disable iff (rst)
    wrCount <= CW'(DEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && !hasRoom && !clr |=> wrReject && (wrCount == $past(wrCount)));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (wrCount == '0) && !wrReject);
endmodule

// File: rtl/antSwitchSeq.sv
module antSwitchSeq
  import antSeqPkg::*;
#(
  parameter int NUM_OUTS = 4,
  parameter int DEPTH    = 40,
  parameter int SLOT_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                patWrEn,
  input  logic [7:0]          patWrData,
  input  logic                patClear,
  input  logic                toneStart,
  input  logic                halfTick,
  input  logic [SLOT_W-1:0]   guardSlots,
  input  logic [SLOT_W-1:0]   refSlots,
  input  logic [SLOT_W-1:0]   switchSlots,
  output logic [NUM_OUTS-1:0] antSel,
  output logic [1:0]          phase,
  output logic                sampleStb,
  output logic                cfgErr,
  output logic                wrReject
);
  phase_e  phaseQ;
  seqCmd_t cmd;
  logic    enough;

  antSeqCtrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clr(patClear), .start(toneStart), .halfTick(halfTick),
    .enough(enough), .guardSlots(guardSlots), .refSlots(refSlots),
    .switchSlots(switchSlots), .phase(phaseQ), .sampleStb(sampleStb),
    .cfgErr(cfgErr), .cmd(cmd)
  );

  antSeqData #(.NUM_OUTS(NUM_OUTS), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .clr(patClear), .wrEn(patWrEn), .wrData(patWrData),
    .phase(phaseQ), .cmd(cmd), .antSel(antSel), .enough(enough),
    .wrReject(wrReject)
  );

  assign phase = phaseQ;
endmodule

// File: tb/antSwitchSeq_bench.sv
`timescale 1ns/1ps
module antSwitchSeq_bench;
  localparam int NO = 4;
  localparam int DP = 40;

  logic clk = 1'b0;
  logic rst, patWrEn, patClear, toneStart, halfTick;
  logic [7:0] patWrData, guardSlots, refSlots, switchSlots;
  logic [NO-1:0] antSel;
  logic [1:0] phase;
  logic sampleStb, cfgErr, wrReject;

  always #2 clk = ~clk;

  antSwitchSeq #(.NUM_OUTS(NO), .DEPTH(DP)) u_antSwitchSeq (
    .clk(clk), .rst(rst), .patWrEn(patWrEn), .patWrData(patWrData),
    .patClear(patClear), .toneStart(toneStart), .halfTick(halfTick),
    .guardSlots(guardSlots), .refSlots(refSlots), .switchSlots(switchSlots),
    .antSel(antSel), .phase(phase), .sampleStb(sampleStb),
    .cfgErr(cfgErr), .wrReject(wrReject)
  );

  typedef struct packed {
    logic [1:0] ph;
    logic [3:0] sel;
    logic stb;
    logic cerr;
    logic rej;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  int mPhase, mCnt, mSw, mCount, mSlot;
  bit mHalf, mErr, mRej;
  int mMem[DP];

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int limitOf(input int ph);
    if (ph == 1) return int'(guardSlots);
    if (ph == 2) return int'(refSlots);
    return int'(switchSlots);
  endfunction

  task automatic modelReset();
    mPhase = 0; mSlot = 0; mSw = 2; mCount = 0; mHalf = 0; mErr = 0; mRej = 0;
    for (int i = 0; i < DP; i++) mMem[i] = 0;
  endtask

  // driver: applies one cycle of stimulus and queues expected outputs
  task automatic cyc(input bit st, input bit tk, input bit cl, input bit we, input int wd);
    exp_t e;
    int idx;
    @(negedge clk);
    toneStart = st; halfTick = tk; patClear = cl; patWrEn = we; patWrData = 8'(wd);
    idx = (mPhase == 0) ? 0 : (mPhase == 3) ? mSw : 1;
    e.ph = 2'(mPhase); e.sel = 4'(mMem[idx]);
    e.stb = tk && !mHalf && (mPhase >= 2);
    e.cerr = mErr; e.rej = mRej;
    expQ.push_back(e);
    if (cl) begin
      modelReset();
    end else begin
      if (mPhase == 0) begin
        if (st) begin
          if (mCount >= 3) begin mPhase = 1; mSlot = 0; mHalf = 0; end
          else mErr = 1;
        end
      end else if (tk) begin
        if (mHalf) begin
          if (mPhase == 3) mSw = (mSw == mCount - 1) ? 2 : mSw + 1;
          if (mSlot == limitOf(mPhase) - 1) begin
            mSlot = 0;
            mPhase = (mPhase + 1) % 4;
            if (mPhase == 3) mSw = 2;
          end else mSlot++;
        end
        mHalf = !mHalf;
      end
      if (we) begin
        if (mCount < DP && wd < (1 << NO)) begin mMem[mCount] = wd; mCount++; end
        else mRej = 1;
      end
    end
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(0, 1, 0, 0, 0);
      for (int g = 0; g < gap; g++) cyc(0, 0, 0, 0, 0);
    end
  endtask

  // monitor: pops and compares each cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        string selTag;
        e = expQ.pop_front();
        selTag = (e.ph == 0) ? "R2 antSel rest" : (e.ph == 3) ? "R5 antSel switch" : "R4 antSel guard/ref";
        chk("R3 phase", int'(phase), int'(e.ph));
        chk(selTag, int'(antSel), int'(e.sel));
        chk("R6 sampleStb", int'(sampleStb), int'(e.stb));
        chk("R7 cfgErr", int'(cfgErr), int'(e.cerr));
        chk("R8 R9 wrReject", int'(wrReject), int'(e.rej));
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rst = 1; patWrEn = 0; patWrData = 0; patClear = 0; toneStart = 0; halfTick = 0;
    guardSlots = 8'd4; refSlots = 8'd8; switchSlots = 8'd7;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset antSel", int'(antSel), 0);
    chk("R1 reset flags", int'({sampleStb, cfgErr, wrReject}), 0);

    // R7: start with empty list, then with two entries
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 3);
    cyc(0, 0, 0, 1, 6);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R7 refused start stays in rest", int'(phase), 0);
    chk("R7 cfgErr sticky", int'(cfgErr), 1);

    // R10: clear drops flags and list
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R10 clear flag", int'(cfgErr), 0);
    chk("R10 clear antSel", int'(antSel), 0);

    // load 5 entries: rest=5, guard=10, switch 1,2,4
    cyc(0, 0, 0, 1, 5);
    cyc(0, 0, 0, 1, 10);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 2);
    cyc(0, 0, 0, 1, 4);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R2 rest shows entry 0", int'(antSel), 5);

    // tone 1: 4 guard, 8 reference, 7 switch slots (wraps twice)
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R11 start while active ignored", int'(phase), 1);
    ticks(20, 1);
    ticks(19, 0);
    ticks(4, 2);
    #1;
    chk("R3 back to rest", int'(phase), 0);

    // R9: out-of-range value
    cyc(0, 0, 0, 1, 8'h13);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R9 out-of-range rejected", int'(wrReject), 1);

    // R8: fill the list and overflow
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < DP + 1; i++) cyc(0, 0, 0, 1, (i * 7 + 3) % 16);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R8 overflow rejected", int'(wrReject), 1);
    guardSlots = 8'd1; refSlots = 8'd1; switchSlots = 8'd40;
    cyc(1, 0, 0, 0, 0);
    ticks(86, 0);
    cyc(0, 0, 0, 0, 0);

    // R10: clear in the middle of a tone
    cyc(1, 0, 0, 0, 0);
    ticks(9, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    #1;
    chk("R10 clear aborts tone", int'(phase), 0);
    chk("R10 clear zeroes antSel", int'(antSel), 0);
    cyc(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #2;
    finish();
  end
endmodule